// File: doc/BRIEF.md
# Descriptor-Ring Serial DMA Engine

This block moves bytes between a serial byte stream and a small shared memory. The memory holds linked descriptors. Each descriptor is eight 32-bit words: a count word at offset 0, a control/status word at offset 1, a next-descriptor pointer at offset 2 and a buffer pointer at offset 3. The data buffer usually sits in the four words after them. The memory is an internal word-addressed RAM. A host port reads it combinationally and writes it on the clock edge, so software can build descriptor rings and inspect the results.

The receive engine walks a closed ring of descriptors. It packs incoming bytes into the buffer of the current descriptor and closes that descriptor in two cases: when the buffer is full, or when the line has been idle for a set number of byte times. It then follows the next pointer. The transmit engine starts on a demand command and sends each owned descriptor's bytes on an output stream that has a ready handshake. It follows the chain until it finds a descriptor the host still owns. In both directions an ownership flag in the control word passes each descriptor between host and hardware.

Both engines are driven through a four-entry register port. Entry 0 is the receive current pointer, entry 1 the transmit current pointer and entry 2 the transmit first pointer. Entry 3 is the command word, whose bits are: bit 0 receive enable, bit 1 receive abort, bit 2 transmit demand, bit 3 transmit abort. A pointer write takes effect only while its engine is stopped.

Top module: `sdma_ring_engine`

## Requirements
- R1: After reset, rx_busy, tx_busy, rx_no_resource and tx_valid are 0 and all three pointer outputs are 0.
- R2: Received bytes are stored little-endian from the buffer pointer upward: byte n goes to word (buffer + n/4), bits 8*(n%4)+7:8*(n%4). A word is zero above the last byte written into it.
- R3: When the received count reaches the capacity held in bits 31:16 of the count word, the engine writes {capacity, count} to the count word. It writes the control word with the ownership bit 31 cleared, first flag bit 17 and last flag bit 16 set, and error bit 15 clear. It then loads the next pointer from offset 2.
- R4: After IDLE_BYTES*BYTE_CLKS clock cycles with no byte and at least one byte stored, the descriptor is closed with the partial count. A descriptor with zero bytes is never closed by idle time.
- R5: A byte that arrives with rx_err set is not stored. It closes the descriptor with bit 15 set in the control word.
- R6: When the receive engine reaches a descriptor whose bit 31 is clear, it stops, raises rx_no_resource and ignores incoming bytes. A later receive enable clears the flag and restarts at the same pointer.
- R7: The receive engine follows next pointers, so a ring whose last next pointer returns to the first descriptor wraps to it.
- R8: After a transmit demand, each owned descriptor's byte count (bits 31:16 of the count word) is sent in little-endian buffer order. Each byte is held on tx_data with tx_valid until tx_ready is seen. The control word is then written back with only bit 31 cleared, and the chain is followed until a descriptor with bit 31 clear is found.
- R9: tx_first_ptr is loaded with the address of each transmit descriptor the engine opens whose first flag (bit 17) is set.
- R10: A receive abort stops the receive engine, and a transmit abort stops the transmit engine and drops tx_valid on the next cycle. Neither abort writes back the open descriptor.
- R11: While the receive engine is stopped, incoming bytes change no memory word and no pointer.
- R12: A transmit descriptor with a byte count of 0 is handed back with bit 31 cleared and sends no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 rx current, 1 tx current, 2 tx first, 3 command |
| reg_wdata | input | 32 | Register write data |
| host_we | input | 1 | Host memory write strobe |
| host_addr | input | AW | Host memory word address |
| host_wdata | input | 32 | Host memory write data |
| host_rdata | output | 32 | Host memory read data (combinational) |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_err | input | 1 | Received byte carries a line error |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Serial side accepts the transmit byte |
| rx_cur_ptr | output | AW | Receive current descriptor pointer |
| tx_cur_ptr | output | AW | Transmit current descriptor pointer |
| tx_first_ptr | output | AW | Transmit first-of-frame descriptor pointer |
| rx_busy | output | 1 | Receive engine running |
| tx_busy | output | 1 | Transmit engine running |
| rx_no_resource | output | 1 | Receive stopped on a host-owned descriptor |

## Verification
The bench fills a buffer exactly to capacity. A wrong compare there would either close one byte early or write beyond the buffer. It lets a partial buffer time out and then waits much longer on an empty one, which catches an idle close that ignores the byte count. It sends a byte flagged as erroneous, wraps the ring onto a descriptor the host still owns, and checks that bytes are then dropped rather than written over the old buffer. On transmit it checks byte order under backpressure, a zero-length descriptor, and an abort while stalled. A design that got any of these wrong would repeat or skip bytes, hang, or hand back a descriptor it never finished.

// File: rtl/sdma_ring_pkg.sv
package sdma_ring_pkg;
  localparam int DW        = 32;
  localparam int OWN_BIT   = 31;
  localparam int FIRST_BIT = 17;
  localparam int LAST_BIT  = 16;
  localparam int ERR_BIT   = 15;
  localparam int W_CNT     = 0;
  localparam int W_CTL     = 1;
  localparam int W_NEXT    = 2;
  localparam int W_BUF     = 3;

  typedef enum logic [2:0] {
    RX_OFF, RX_CHK, RX_CAP, RX_BUF, RX_RECV, RX_CLS0, RX_CLS1, RX_NEXT
  } rx_state_t;

  typedef enum logic [2:0] {
    TX_OFF, TX_CHK, TX_CNT, TX_BUF, TX_LOAD, TX_SEND, TX_CLS, TX_NEXT
  } tx_state_t;
endpackage

// File: rtl/sdma_desc_ram.sv
module sdma_desc_ram #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  logic [31:0]   h_wdata,
  output logic [31:0]   h_rdata,
  input  logic          r_we,
  input  logic [AW-1:0] r_addr,
  input  logic [31:0]   r_wdata,
  output logic [31:0]   r_rdata,
  input  logic          t_we,
  input  logic [AW-1:0] t_addr,
  input  logic [31:0]   t_wdata,
  output logic [31:0]   t_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (t_we) mem[t_addr] <= t_wdata;
    if (r_we) mem[r_addr] <= r_wdata;
    if (h_we) mem[h_addr] <= h_wdata;
  end

  assign h_rdata = mem[h_addr];
  assign r_rdata = mem[r_addr];
  assign t_rdata = mem[t_addr];
endmodule

// File: rtl/sdma_rx_eng.sv
module sdma_rx_eng
  import sdma_ring_pkg::*;
#(
  parameter int AW         = 7,
  parameter int IDLE_LIMIT = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_en,
  input  logic          cmd_abort,
  input  logic          ptr_ld,
  input  logic [AW-1:0] ptr_wdata,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_err,
  output logic [AW-1:0] m_addr,
  output logic          m_we,
  output logic [31:0]   m_wdata,
  input  logic [31:0]   m_rdata,
  output logic [AW-1:0] cur_ptr,
  output logic          busy,
  output logic          no_res
);
  localparam int IW = $clog2(IDLE_LIMIT + 1);

  rx_state_t     state, state_n;
  logic [AW-1:0] cur, cur_n;
  logic [AW-1:0] bufp, bufp_n;
  logic [15:0]   cap, cap_n;
  logic [15:0]   cnt, cnt_n;
  logic [31:0]   acc, acc_n;
  logic [IW-1:0] idle, idle_n;
  logic          err_f, err_n;
  logic          nores, nores_n;
  logic [31:0]   wr_word;
  logic [1:0]    lane;
  logic          unused_rd;

  assign unused_rd = ^m_rdata;
  assign lane      = cnt[1:0];
  assign wr_word   = (lane == 2'd0) ? {24'b0, in_data}
                                    : (acc | (32'(in_data) << {lane, 3'b000}));

  always_comb begin
    state_n = state;
    cur_n   = cur;
    bufp_n  = bufp;
    cap_n   = cap;
    cnt_n   = cnt;
    acc_n   = acc;
    idle_n  = idle;
    err_n   = err_f;
    nores_n = nores;
    m_addr  = cur;
    m_we    = 1'b0;
    m_wdata = '0;
    case (state)
      RX_OFF: begin
        if (ptr_ld) cur_n = ptr_wdata;
        if (cmd_en) begin
          state_n = RX_CHK;
          nores_n = 1'b0;
        end
      end
      RX_CHK: begin
        m_addr = cur + AW'(W_CTL);
        if (m_rdata[OWN_BIT]) begin
          state_n = RX_CAP;
        end else begin
          nores_n = 1'b1;
          state_n = RX_OFF;
        end
      end
      RX_CAP: begin
        m_addr  = cur + AW'(W_CNT);
        cap_n   = m_rdata[31:16];
        state_n = RX_BUF;
      end
      RX_BUF: begin
        m_addr  = cur + AW'(W_BUF);
        bufp_n  = m_rdata[AW-1:0];
        cnt_n   = '0;
        acc_n   = '0;
        idle_n  = '0;
        err_n   = 1'b0;
        state_n = RX_RECV;
      end
      RX_RECV: begin
        if (in_valid) begin
          idle_n = '0;
          if (in_err) begin
            err_n   = 1'b1;
            state_n = RX_CLS0;
          end else begin
            m_addr  = bufp + AW'(cnt >> 2);
            m_we    = 1'b1;
            m_wdata = wr_word;
            acc_n   = (lane == 2'd3) ? '0 : wr_word;
            cnt_n   = cnt + 16'd1;
            if (cnt + 16'd1 == cap) state_n = RX_CLS0;
          end
        end else begin
          if (idle != IW'(IDLE_LIMIT)) idle_n = idle + IW'(1);
          if ((cnt != 16'd0) && (idle == IW'(IDLE_LIMIT - 1))) state_n = RX_CLS0;
        end
      end
      RX_CLS0: begin
        m_addr  = cur + AW'(W_CNT);
        m_we    = 1'b1;
        m_wdata = {cap, cnt};
        state_n = RX_CLS1;
      end
      RX_CLS1: begin
        m_addr  = cur + AW'(W_CTL);
        m_we    = 1'b1;
        m_wdata = (32'd1 << FIRST_BIT) | (32'd1 << LAST_BIT) | (32'(err_f) << ERR_BIT);
        state_n = RX_NEXT;
      end
      RX_NEXT: begin
        m_addr  = cur + AW'(W_NEXT);
        cur_n   = m_rdata[AW-1:0];
        state_n = RX_CHK;
      end
      default: state_n = RX_OFF;
    endcase
    if (cmd_abort) begin
      state_n = RX_OFF;
      m_we    = 1'b0;
      nores_n = nores;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_OFF;
      cur   <= '0;
      bufp  <= '0;
      cap   <= '0;
      cnt   <= '0;
      acc   <= '0;
      idle  <= '0;
      err_f <= 1'b0;
      nores <= 1'b0;
    end else begin
      state <= state_n;
      cur   <= cur_n;
      bufp  <= bufp_n;
      cap   <= cap_n;
      cnt   <= cnt_n;
      acc   <= acc_n;
      idle  <= idle_n;
      err_f <= err_n;
      nores <= nores_n;
    end
  end

  assign cur_ptr = cur;
  assign busy    = (state != RX_OFF);
  assign no_res  = nores;

  AST_RX_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_RECV && cap != 16'd0) |-> (cnt < cap)); // R3
  AST_RX_NORES_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    nores |-> (state == RX_OFF)); // R6
  AST_RX_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_abort |=> (state == RX_OFF)); // R10
  AST_RX_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_OFF && in_valid) |=> $stable(cur) || $past(ptr_ld)); // R11
endmodule

// File: rtl/sdma_tx_eng.sv
module sdma_tx_eng
  import sdma_ring_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_demand,
  input  logic          cmd_abort,
  input  logic          cur_ld,
  input  logic          first_ld,
  input  logic [AW-1:0] ptr_wdata,
  output logic          out_valid,
  output logic [7:0]    out_data,
  input  logic          out_ready,
  output logic [AW-1:0] m_addr,
  output logic          m_we,
  output logic [31:0]   m_wdata,
  input  logic [31:0]   m_rdata,
  output logic [AW-1:0] cur_ptr,
  output logic [AW-1:0] first_ptr,
  output logic          busy
);
  tx_state_t     state, state_n;
  logic [AW-1:0] cur, cur_n;
  logic [AW-1:0] first, first_n;
  logic [AW-1:0] bufp, bufp_n;
  logic [31:0]   ctl, ctl_n;
  logic [15:0]   cnt, cnt_n;
  logic [15:0]   idx, idx_n;
  logic [31:0]   word, word_n;
  logic          unused_rd;

  assign unused_rd = ^m_rdata;
  assign out_valid = (state == TX_SEND);
  assign out_data  = 8'(word >> {idx[1:0], 3'b000});

  always_comb begin
    state_n = state;
    cur_n   = cur;
    first_n = first;
    bufp_n  = bufp;
    ctl_n   = ctl;
    cnt_n   = cnt;
    idx_n   = idx;
    word_n  = word;
    m_addr  = cur;
    m_we    = 1'b0;
    m_wdata = '0;
    case (state)
      TX_OFF: begin
        if (cur_ld)   cur_n   = ptr_wdata;
        if (first_ld) first_n = ptr_wdata;
        if (cmd_demand) state_n = TX_CHK;
      end
      TX_CHK: begin
        m_addr = cur + AW'(W_CTL);
        if (m_rdata[OWN_BIT]) begin
          ctl_n = m_rdata;
          if (m_rdata[FIRST_BIT]) first_n = cur;
          state_n = TX_CNT;
        end else begin
          state_n = TX_OFF;
        end
      end
      TX_CNT: begin
        m_addr  = cur + AW'(W_CNT);
        cnt_n   = m_rdata[31:16];
        idx_n   = '0;
        state_n = TX_BUF;
      end
      TX_BUF: begin
        m_addr  = cur + AW'(W_BUF);
        bufp_n  = m_rdata[AW-1:0];
        state_n = (cnt == 16'd0) ? TX_CLS : TX_LOAD;
      end
      TX_LOAD: begin
        m_addr  = bufp + AW'(idx >> 2);
        word_n  = m_rdata;
        state_n = TX_SEND;
      end
      TX_SEND: begin
        if (out_ready) begin
          idx_n = idx + 16'd1;
          if (idx + 16'd1 == cnt)   state_n = TX_CLS;
          else if (idx[1:0] == 2'd3) state_n = TX_LOAD;
        end
      end
      TX_CLS: begin
        m_addr  = cur + AW'(W_CTL);
        m_we    = 1'b1;
        m_wdata = ctl & ~(32'd1 << OWN_BIT);
        state_n = TX_NEXT;
      end
      TX_NEXT: begin
        m_addr  = cur + AW'(W_NEXT);
        cur_n   = m_rdata[AW-1:0];
        state_n = TX_CHK;
      end
      default: state_n = TX_OFF;
    endcase
    if (cmd_abort) begin
      state_n = TX_OFF;
      m_we    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= TX_OFF;
      cur   <= '0;
      first <= '0;
      bufp  <= '0;
      ctl   <= '0;
      cnt   <= '0;
      idx   <= '0;
      word  <= '0;
    end else begin
      state <= state_n;
      cur   <= cur_n;
      first <= first_n;
      bufp  <= bufp_n;
      ctl   <= ctl_n;
      cnt   <= cnt_n;
      idx   <= idx_n;
      word  <= word_n;
    end
  end

  assign cur_ptr   = cur;
  assign first_ptr = first;
  assign busy      = (state != TX_OFF);

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !cmd_abort) |=> (out_valid && $stable(out_data))); // R8
  AST_TX_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_SEND) |-> (idx < cnt)); // R8
  AST_TX_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_abort |=> !out_valid); // R10
  AST_TX_WB_CLEARS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    m_we |-> !m_wdata[OWN_BIT]); // R12
endmodule

// File: rtl/sdma_ring_engine.sv
module sdma_ring_engine #(
  parameter int AW         = 7,
  parameter int IDLE_BYTES = 4,
  parameter int BYTE_CLKS  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_err,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  input  logic          tx_ready,
  output logic [AW-1:0] rx_cur_ptr,
  output logic [AW-1:0] tx_cur_ptr,
  output logic [AW-1:0] tx_first_ptr,
  output logic          rx_busy,
  output logic          tx_busy,
  output logic          rx_no_resource
);
  localparam int IDLE_LIMIT = IDLE_BYTES * BYTE_CLKS;

  logic          cmd_wr;
  logic          rx_en_c, rx_ab_c, tx_dm_c, tx_ab_c;
  logic          rx_ld, txc_ld, txf_ld;
  logic [AW-1:0] ptr_wd;
  logic          unused_reg;
  logic [AW-1:0] r_addr, t_addr;
  logic          r_we, t_we;
  logic [31:0]   r_wdata, t_wdata, r_rdata, t_rdata;

  assign cmd_wr     = reg_we && (reg_sel == 2'd3);
  assign rx_ab_c    = cmd_wr && reg_wdata[1];
  assign rx_en_c    = cmd_wr && reg_wdata[0] && !reg_wdata[1];
  assign tx_ab_c    = cmd_wr && reg_wdata[3];
  assign tx_dm_c    = cmd_wr && reg_wdata[2] && !reg_wdata[3];
  assign rx_ld      = reg_we && (reg_sel == 2'd0);
  assign txc_ld     = reg_we && (reg_sel == 2'd1);
  assign txf_ld     = reg_we && (reg_sel == 2'd2);
  assign ptr_wd     = reg_wdata[AW-1:0];
  assign unused_reg = ^reg_wdata;

  sdma_desc_ram #(.AW(AW)) u_ram (
    .clk(clk),
    .h_we(host_we), .h_addr(host_addr), .h_wdata(host_wdata), .h_rdata(host_rdata),
    .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
    .t_we(t_we), .t_addr(t_addr), .t_wdata(t_wdata), .t_rdata(t_rdata)
  );

  sdma_rx_eng #(.AW(AW), .IDLE_LIMIT(IDLE_LIMIT)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .cmd_en(rx_en_c), .cmd_abort(rx_ab_c),
    .ptr_ld(rx_ld), .ptr_wdata(ptr_wd),
    .in_valid(rx_valid), .in_data(rx_data), .in_err(rx_err),
    .m_addr(r_addr), .m_we(r_we), .m_wdata(r_wdata), .m_rdata(r_rdata),
    .cur_ptr(rx_cur_ptr), .busy(rx_busy), .no_res(rx_no_resource)
  );

  sdma_tx_eng #(.AW(AW)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .cmd_demand(tx_dm_c), .cmd_abort(tx_ab_c),
    .cur_ld(txc_ld), .first_ld(txf_ld), .ptr_wdata(ptr_wd),
    .out_valid(tx_valid), .out_data(tx_data), .out_ready(tx_ready),
    .m_addr(t_addr), .m_we(t_we), .m_wdata(t_wdata), .m_rdata(t_rdata),
    .cur_ptr(tx_cur_ptr), .first_ptr(tx_first_ptr), .busy(tx_busy)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!rx_busy && !tx_busy && !tx_valid)); // R1
endmodule

// File: tb/sim_sdma_ring_engine.sv
module sim_sdma_ring_engine;
  localparam int AW = 7;

  logic          clk, rst_n;
  logic          reg_we;
  logic [1:0]    reg_sel;
  logic [31:0]   reg_wdata;
  logic          host_we;
  logic [AW-1:0] host_addr;
  logic [31:0]   host_wdata, host_rdata;
  logic          rx_valid, rx_err;
  logic [7:0]    rx_data;
  logic          tx_valid, tx_ready;
  logic [7:0]    tx_data;
  logic [AW-1:0] rx_cur_ptr, tx_cur_ptr, tx_first_ptr;
  logic          rx_busy, tx_busy, rx_no_resource;

  int total = 0;
  int bad   = 0;
  int rdy_mode = 0;
  int ncap = 0;
  logic [7:0] capb [64];

  sdma_ring_engine #(.AW(AW), .IDLE_BYTES(4), .BYTE_CLKS(10)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_cur_ptr(rx_cur_ptr), .tx_cur_ptr(tx_cur_ptr), .tx_first_ptr(tx_first_ptr),
    .rx_busy(rx_busy), .tx_busy(tx_busy), .rx_no_resource(rx_no_resource)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (rdy_mode == 0)      tx_ready <= 1'b1;
    else if (rdy_mode == 1) tx_ready <= ~tx_ready;
    else                    tx_ready <= 1'b0;
  end

  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready && ncap < 64) begin
      capb[ncap] = tx_data;
      ncap = ncap + 1;
    end
  end

  initial begin
    #1000000;
    bad = bad + 1;
    total = total + 1;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mem(input int a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = AW'(a); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd_mem(input int a, output logic [31:0] d);
    host_addr = AW'(a);
    #0.5;
    d = host_rdata;
  endtask

  task automatic reg_wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic e);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b; rx_err = e;
    @(negedge clk);
    rx_valid = 1'b0; rx_err = 1'b0;
    cyc(8);
  endtask

  task automatic wait_tx_idle;
    cyc(3);
    for (int i = 0; i < 1000 && tx_busy; i++) cyc(1);
  endtask

  task automatic chk_mem(input string tag, input int a, input logic [31:0] exp);
    logic [31:0] d;
    rd_mem(a, d);
    chk(tag, d, exp);
  endtask

  task automatic t_reset;
    chk("R1 rx_busy", {31'b0, rx_busy}, 0);
    chk("R1 tx_busy", {31'b0, tx_busy}, 0);
    chk("R1 no_resource", {31'b0, rx_no_resource}, 0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 0);
    chk("R1 pointers", {11'b0, rx_cur_ptr, tx_cur_ptr, tx_first_ptr}, 0);
  endtask

  task automatic t_ring_init;
    for (int k = 0; k < 3; k++) begin
      wr_mem(k*8 + 0, 32'h0010_0000);
      wr_mem(k*8 + 1, 32'h8003_0000);
      wr_mem(k*8 + 2, (k == 2) ? 32'd0 : 32'(k*8 + 8));
      wr_mem(k*8 + 3, 32'(k*8 + 4));
      for (int w = 4; w < 8; w++) wr_mem(k*8 + w, 32'h5555_5555);
    end
  endtask

  task automatic t_rx_disabled;
    send_byte(8'h99, 1'b0);
    chk_mem("R11 buffer untouched", 4, 32'h5555_5555);
    chk_mem("R11 status untouched", 1, 32'h8003_0000);
    chk("R11 pointer", 32'(rx_cur_ptr), 0);
  endtask

  task automatic t_rx_full;
    reg_wr(2'd3, 32'h1);
    cyc(10);
    for (int i = 0; i < 16; i++) send_byte(8'h10 + 8'(i), 1'b0);
    cyc(10);
    chk_mem("R2 first word", 4, 32'h1312_1110);
    chk_mem("R2 last word", 7, 32'h1F1E_1D1C);
    chk_mem("R3 count word", 0, 32'h0010_0010);
    chk_mem("R3 status word", 1, 32'h0003_0000);
    chk("R3 next pointer", 32'(rx_cur_ptr), 8);
  endtask

  task automatic t_rx_idle;
    for (int i = 0; i < 5; i++) send_byte(8'hA0 + 8'(i), 1'b0);
    cyc(60);
    chk_mem("R4 count word", 8, 32'h0010_0005);
    chk_mem("R2 packed word", 12, 32'hA3A2_A1A0);
    chk_mem("R2 partial word", 13, 32'h0000_00A4);
    chk_mem("R4 status word", 9, 32'h0003_0000);
    chk("R4 advanced", 32'(rx_cur_ptr), 16);
    cyc(100);
    chk_mem("R4 empty not closed", 17, 32'h8003_0000);
  endtask

  task automatic t_rx_error_wrap;
    send_byte(8'h01, 1'b0);
    send_byte(8'h02, 1'b0);
    send_byte(8'h77, 1'b1);
    cyc(10);
    chk_mem("R5 status err", 17, 32'h0003_8000);
    chk_mem("R5 count", 16, 32'h0010_0002);
    chk_mem("R5 data", 20, 32'h0000_0201);
    chk("R7 wrapped", 32'(rx_cur_ptr), 0);
    chk("R6 no_resource", {31'b0, rx_no_resource}, 1);
    chk("R6 stopped", {31'b0, rx_busy}, 0);
  endtask

  task automatic t_rx_rearm;
    send_byte(8'hEE, 1'b0);
    chk_mem("R6 byte ignored", 4, 32'h1312_1110);
    wr_mem(0, 32'h0010_0000);
    wr_mem(1, 32'h8003_0000);
    reg_wr(2'd3, 32'h1);
    cyc(5);
    chk("R6 flag cleared", {31'b0, rx_no_resource}, 0);
    chk("R6 restarted", {31'b0, rx_busy}, 1);
  endtask

  task automatic t_rx_abort;
    send_byte(8'hC0, 1'b0);
    send_byte(8'hC1, 1'b0);
    send_byte(8'hC2, 1'b0);
    reg_wr(2'd3, 32'h2);
    cyc(60);
    chk("R10 rx stopped", {31'b0, rx_busy}, 0);
    chk_mem("R10 no writeback", 1, 32'h8003_0000);
    chk_mem("R2 three bytes", 4, 32'h00C2_C1C0);
  endtask

  task automatic t_tx_chain;
    int base;
    wr_mem(32, 32'h0006_0006); wr_mem(33, 32'h8002_0000);
    wr_mem(34, 32'd40);        wr_mem(35, 32'd36);
    wr_mem(36, 32'h6463_6261); wr_mem(37, 32'h0000_6665);
    wr_mem(40, 32'h0003_0003); wr_mem(41, 32'h8001_0000);
    wr_mem(42, 32'd48);        wr_mem(43, 32'd44);
    wr_mem(44, 32'h0073_7271);
    wr_mem(48, 32'h0004_0004); wr_mem(49, 32'h0000_0000);
    wr_mem(50, 32'd32);        wr_mem(51, 32'd52);
    wr_mem(52, 32'h8483_8281);
    reg_wr(2'd1, 32'd32);
    base = ncap;
    reg_wr(2'd3, 32'h4);
    wait_tx_idle();
    chk("R8 byte total", 32'(ncap - base), 9);
    for (int i = 0; i < 6; i++) chk("R8 first frame byte", 32'(capb[base+i]), 32'h61 + 32'(i));
    for (int i = 0; i < 3; i++) chk("R8 second frame byte", 32'(capb[base+6+i]), 32'h71 + 32'(i));
    chk_mem("R8 handback 1", 33, 32'h0002_0000);
    chk_mem("R8 handback 2", 41, 32'h0001_0000);
    chk("R8 stop pointer", 32'(tx_cur_ptr), 48);
    chk("R9 first pointer", 32'(tx_first_ptr), 32);
  endtask

  task automatic t_tx_backpressure;
    int base;
    wr_mem(49, 32'h8003_0000);
    rdy_mode = 1;
    base = ncap;
    reg_wr(2'd3, 32'h4);
    wait_tx_idle();
    rdy_mode = 0;
    chk("R8 bp byte total", 32'(ncap - base), 4);
    for (int i = 0; i < 4; i++) chk("R8 bp byte", 32'(capb[base+i]), 32'h81 + 32'(i));
    chk("R9 first moved", 32'(tx_first_ptr), 48);
    chk("R8 bp stop pointer", 32'(tx_cur_ptr), 32);
  endtask

  task automatic t_tx_zero;
    int base;
    wr_mem(32, 32'h0000_0000);
    wr_mem(33, 32'h8000_0000);
    base = ncap;
    reg_wr(2'd3, 32'h4);
    wait_tx_idle();
    chk("R12 no bytes", 32'(ncap - base), 0);
    chk_mem("R12 handed back", 33, 32'h0000_0000);
    chk("R12 moved on", 32'(tx_cur_ptr), 40);
    chk("R9 first kept", 32'(tx_first_ptr), 48);
  endtask

  task automatic t_tx_abort;
    wr_mem(40, 32'h0008_0008);
    wr_mem(41, 32'h8001_0000);
    rdy_mode = 2;
    reg_wr(2'd3, 32'h4);
    cyc(10);
    chk("R8 stalled valid", {31'b0, tx_valid}, 1);
    chk("R8 stalled data", 32'(tx_data), 32'h71);
    reg_wr(2'd3, 32'h8);
    cyc(2);
    chk("R10 tx_valid dropped", {31'b0, tx_valid}, 0);
    chk("R10 tx stopped", {31'b0, tx_busy}, 0);
    chk_mem("R10 tx no writeback", 41, 32'h8001_0000);
    rdy_mode = 0;
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
    host_we = 1'b0; host_addr = '0; host_wdata = '0;
    rx_valid = 1'b0; rx_data = '0; rx_err = 1'b0;
    cyc(4);
    t_reset();
    rst_n = 1'b1;
    cyc(2);
    t_ring_init();
    t_rx_disabled();
    t_rx_full();
    t_rx_idle();
    t_rx_error_wrap();
    t_rx_rearm();
    t_rx_abort();
    t_tx_chain();
    t_tx_backpressure();
    t_tx_zero();
    t_tx_abort();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule